// File: doc/BRIEF.md
# Wait Pin and Controller Event Interrupt Hub

This block gathers interrupt sources from a parallel memory controller and turns them into one interrupt line. Two sources are internal controller strobes: a FIFO-threshold event and a transfer terminal-count event. The rest are external wait pins. The number of wait pins is a parameter. Each wait pin is brought into the clock domain through a two-flop synchronizer. Its edges are then detected, and each pin has its own polarity bit that chooses rising-edge or falling-edge detection.

Every source owns a fixed interrupt index. The FIFO event is index 0 and the terminal-count event is index 1. Wait pin k is index 2+k. Each index has three controls: an enable bit, a pending bit that software clears by writing 1, and a contribution to the interrupt output. The synchronized wait-pin levels can also be read back as general-purpose inputs.

Access goes through a small register port. It has a 2-bit word address and a data width of 2 plus the number of wait pins. Writes take effect on the clock edge, and reads are combinational.

Top module: `evt_irq_hub`

## Requirements
- R1: After a synchronous active-low reset, these are all zero: the enable register, the pending register, the polarity register and the synchronized pin levels. The output `irq` is low.
- R2: A cycle with `fifo_evt` high sets pending bit 0 at the next clock edge.
- R3: A cycle with `tc_evt` high sets pending bit 1 at the next clock edge.
- R4: When polarity bit k is 0, a rising edge on `wait_pin[k]` sets pending bit 2+k. It becomes visible 3 clock edges after the pin changes, and not earlier. A falling edge on that pin has no effect.
- R5: When polarity bit k is 1, a falling edge on `wait_pin[k]` sets pending bit 2+k with the same latency. A rising edge on that pin has no effect.
- R6: A pending bit stays set until software writes to address 1 with a 1 in that bit position. Bit positions written as 0 leave their pending bits unchanged.
- R7: If a source event and a clear of the same bit occur in the same cycle, the bit ends up set.
- R8: `irq` is the OR over all indices of the pending bit ANDed with the enable bit. The enable register is read/write at address 0, and bit i enables index i.
- R9: Address 3 returns the synchronized wait-pin levels, with bit k for wait pin k. A pin change shows there 2 clock edges later.
- R10: The polarity register is at address 2, and bit k is for wait pin k. Only its low NUM_WAIT bits are stored. The bits above them read as 0. Address 1 reads back the pending bits at their index positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_evt | input | 1 | FIFO-threshold event strobe (index 0) |
| tc_evt | input | 1 | Terminal-count event strobe (index 1) |
| wait_pin | input | NUM_WAIT | Asynchronous wait pins (index 2+k) |
| reg_addr | input | 2 | Register word address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | NUM_WAIT+2 | Register write data |
| reg_rdata | output | NUM_WAIT+2 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The interrupt path is swept over every one of the 16 enable masks crossed with every one of the 16 pending patterns. Each pattern is built by firing the real sources, so a wrong index mapping is told apart from a wrong OR/AND combination. The wait-pin path is swept over every pin, both polarities and both transition directions. The pending bit is sampled one cycle before and at the expected edge, which tells a wrong polarity apart from a synchronizer of the wrong depth. Clear-alone and clear-with-event cycles tell apart write-one-to-clear behaviour and event priority.

// File: rtl/evt_irq_pkg.sv
// Shared constants for the event interrupt hub: register word addresses
// and the count of internal controller events that precede the pins.
package evt_irq_pkg;
    localparam int          NUM_EVT   = 2;
    localparam int          REG_AW    = 2;
    localparam logic [1:0]  ADDR_EN   = 2'd0;
    localparam logic [1:0]  ADDR_PEND = 2'd1;
    localparam logic [1:0]  ADDR_POL  = 2'd2;
    localparam logic [1:0]  ADDR_LVL  = 2'd3;
endpackage

// File: rtl/wait_edge_detect.sv
// Per-pin synchronizer and edge detector.
// Each asynchronous pin passes through two flops. A third flop holds the
// previous synchronized level. The selected edge gives a one-cycle pulse.
// Assumes pins are held stable long enough to be seen by the synchronizer.
module wait_edge_detect #(
    parameter int NUM_WAIT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WAIT-1:0] pin_async,
    input  logic [NUM_WAIT-1:0] fall_sel,
    output logic [NUM_WAIT-1:0] level,
    output logic [NUM_WAIT-1:0] edge_evt
);
    genvar k;
    generate
        for (k = 0; k < NUM_WAIT; k++) begin : g_pin
            logic s1_q, s2_q, s3_q;
            logic rise_w, fall_w;

            // Synchronizer chain plus history flop.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1_q <= 1'b0;
                    s2_q <= 1'b0;
                    s3_q <= 1'b0;
                end else begin
                    s1_q <= pin_async[k];
                    s2_q <= s1_q;
                    s3_q <= s2_q;
                end
            end

            // Raw edges and polarity selection.
            always_comb begin
                rise_w      = s2_q & ~s3_q;
                fall_w      = ~s2_q & s3_q;
                edge_evt[k] = fall_sel[k] ? fall_w : rise_w;
                level[k]    = s2_q;
            end

            assert_rise_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
                rise_w |=> !rise_w);
            assert_fall_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
                fall_w |=> !fall_w);
        end
    endgenerate
endmodule

// File: rtl/pending_bank.sv
// Pending-bit bank with write-one-to-clear and combined interrupt output.
// A set in the same cycle as a clear wins. Assumes set and clear are
// single-cycle qualified vectors from the caller.
module pending_bank #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_vec,
    input  logic [NUM_SRC-1:0] en_vec,
    output logic [NUM_SRC-1:0] pending,
    output logic               irq
);
    logic [NUM_SRC-1:0] pend_q;

    // Update pending bits: clear first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    // Combine enabled pending bits into one request.
    always_comb begin
        pending = pend_q;
        irq     = |(pend_q & en_vec);
    end

    assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));
    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend_q ^ $past(pend_q)) & ~$past(set_vec | clr_vec)) == '0));
endmodule

// File: rtl/evt_irq_hub.sv
// Top of the event interrupt hub.
// Maps the FIFO event to index 0, the terminal-count event to index 1 and
// the wait pin k edge to index 2+k. It holds the enable and polarity
// registers and decodes the register port.
// Assumes the event strobes are synchronous to clk.
module evt_irq_hub
    import evt_irq_pkg::*;
#(
    parameter int NUM_WAIT = 2,
    localparam int NUM_SRC = NUM_EVT + NUM_WAIT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_evt,
    input  logic                tc_evt,
    input  logic [NUM_WAIT-1:0] wait_pin,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_wen,
    input  logic [NUM_SRC-1:0]  reg_wdata,
    output logic [NUM_SRC-1:0]  reg_rdata,
    output logic                irq
);
    logic [NUM_SRC-1:0]  en_q;
    logic [NUM_WAIT-1:0] pol_q;
    logic [NUM_WAIT-1:0] pin_level;
    logic [NUM_WAIT-1:0] pin_edge;
    logic [NUM_SRC-1:0]  set_vec;
    logic [NUM_SRC-1:0]  clr_vec;
    logic [NUM_SRC-1:0]  pending;

    wait_edge_detect #(.NUM_WAIT(NUM_WAIT)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (wait_pin),
        .fall_sel  (pol_q),
        .level     (pin_level),
        .edge_evt  (pin_edge)
    );

    // Assemble source vector and the write-one-to-clear mask.
    always_comb begin
        set_vec = {pin_edge, tc_evt, fifo_evt};
        clr_vec = (reg_wen && reg_addr == ADDR_PEND) ? reg_wdata : '0;
    end

    pending_bank #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_vec  (en_q),
        .pending (pending),
        .irq     (irq)
    );

    // Enable and polarity configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
        end else if (reg_wen) begin
            if (reg_addr == ADDR_EN)  en_q  <= reg_wdata;
            if (reg_addr == ADDR_POL) pol_q <= reg_wdata[NUM_WAIT-1:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            ADDR_EN:   reg_rdata = en_q;
            ADDR_PEND: reg_rdata = pending;
            ADDR_POL:  reg_rdata = {{NUM_EVT{1'b0}}, pol_q};
            default:   reg_rdata = {{NUM_EVT{1'b0}}, pin_level};
        endcase
    end

    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |-> !irq);
    assert_enable_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == ADDR_EN) |=> (en_q == $past(reg_wdata)));
    assert_pol_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == ADDR_POL) |=> (pol_q == $past(reg_wdata[NUM_WAIT-1:0])));
endmodule

// File: tb/evt_irq_hub_bench.sv
// Self-checking bench: sweeps enable masks against pending patterns and every
// pin/polarity/direction combination, with expectations computed here.
module evt_irq_hub_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 2;
    localparam int NS = NW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_evt = 1'b0;
    logic          tc_evt = 1'b0;
    logic [NW-1:0] wait_pin = '0;
    logic [1:0]    reg_addr = '0;
    logic          reg_wen = 1'b0;
    logic [NS-1:0] reg_wdata = '0;
    logic [NS-1:0] reg_rdata;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [NW-1:0] pol_shadow = '0;

    evt_irq_hub #(.NUM_WAIT(NW)) u_evt_irq_hub (
        .clk(clk), .rst_n(rst_n), .fifo_evt(fifo_evt), .tc_evt(tc_evt),
        .wait_pin(wait_pin), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        step(1);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [NS-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Fire one source so that its pending bit gets set.
    task automatic fire(input int s);
        if (s == 0) begin
            fifo_evt = 1'b1; step(1); fifo_evt = 1'b0;
        end else if (s == 1) begin
            tc_evt = 1'b1; step(1); tc_evt = 1'b0;
        end else begin
            pol_shadow[s-2] = wait_pin[s-2];
            wr(2'd2, NS'(pol_shadow));
            wait_pin[s-2] = ~wait_pin[s-2];
            step(3);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NS-1:0] d;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        rd(2'd0, d); check("R1 enable", d, 0);
        rd(2'd1, d); check("R1 pending", d, 0);
        rd(2'd2, d); check("R1 polarity", d, 0);
        rd(2'd3, d); check("R1 level", d, 0);
        check("R1 irq", irq, 0);

        // R10: polarity stores only low bits
        wr(2'd2, NS'('1));
        rd(2'd2, d); check("R10 polarity width", d, (1 << NW) - 1);
        wr(2'd2, '0); pol_shadow = '0;

        // R2/R3: single-cycle event latency
        fifo_evt = 1'b1; step(1); fifo_evt = 1'b0;
        rd(2'd1, d); check("R2 fifo sets bit0", d, 1);
        tc_evt = 1'b1; step(1); tc_evt = 1'b0;
        rd(2'd1, d); check("R3 tc sets bit1", d, 3);

        // R6: partial clear, zero bits untouched
        wr(2'd1, NS'(1));
        rd(2'd1, d); check("R6 partial clear", d, 2);
        step(4);
        rd(2'd1, d); check("R6 hold", d, 2);
        wr(2'd1, NS'(2));
        rd(2'd1, d); check("R6 clear", d, 0);

        // R7: event and clear in the same cycle
        fire(0);
        fifo_evt = 1'b1; reg_addr = 2'd1; reg_wdata = NS'(1); reg_wen = 1'b1;
        step(1);
        fifo_evt = 1'b0; reg_wen = 1'b0;
        rd(2'd1, d); check("R7 event wins", d, 1);
        wr(2'd1, NS'('1));

        // R4/R5/R9: every pin, polarity and direction
        for (int k = 0; k < NW; k++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    logic [NS-1:0] exp_pend;
                    logic [NW-1:0] lvl_before;
                    if (wait_pin[k] != dir[0]) begin
                        wait_pin[k] = dir[0];
                        step(4);
                    end
                    pol_shadow[k] = pol[0];
                    wr(2'd2, NS'(pol_shadow));
                    wr(2'd1, NS'('1));
                    lvl_before = wait_pin;
                    wait_pin[k] = ~dir[0];
                    step(1);
                    rd(2'd3, d); check("R9 level not yet", d, NS'(lvl_before));
                    step(1);
                    rd(2'd3, d); check("R9 level", d, NS'(wait_pin));
                    rd(2'd1, d); check("R4 not early", d, 0);
                    step(1);
                    exp_pend = ((dir == 0 && pol == 0) || (dir == 1 && pol == 1))
                               ? NS'(1 << (2 + k)) : '0;
                    rd(2'd1, d);
                    check(pol == 0 ? "R4 rising polarity" : "R5 falling polarity", d, exp_pend);
                end
            end
        end

        // R8/R6: all enable masks against all pending patterns
        for (int en = 0; en < (1 << NS); en++) begin
            wr(2'd0, NS'(en));
            rd(2'd0, d); check("R8 enable readback", d, en);
            for (int p = 0; p < (1 << NS); p++) begin
                wr(2'd1, NS'('1));
                for (int s = 0; s < NS; s++)
                    if (p[s]) fire(s);
                rd(2'd1, d); check("R6 pattern", d, p);
                check("R8 irq", irq, ((p & en) != 0) ? 1 : 0);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule